// File: doc/BRIEF.md
# Event Counter Bank with Limit Interrupts

A bank of programmable event counters. Each counter picks one line from a wide set of event inputs. On every clock where that line is high, and the current privilege level is not filtered out, the counter adds one. Software sets the starting count and a limit through a word-addressed register port. The count and the limit are each 48 bits wide and are split across two 32-bit words. When a counting step lands exactly on the limit, the counter raises its own sticky flag, provided its interrupt enable is set. It then keeps counting, so software can later see how far the count has run past the limit. All flags are ORed onto one interrupt line. That line stays high until software has cleared every raised flag through a write-one-to-clear status word.

Each counter has a two-state machine. In CTR_ARMED the counter watches for a step onto its limit; such a step with interrupts enabled takes it to CTR_FLAGGED (transition "limit hit"). In CTR_FLAGGED a one written to its status bit takes it back to CTR_ARMED (transition "software clear"). When a clear and a new limit hit fall in the same cycle, the hit wins. Any other cycle leaves the state unchanged. A separate snapshot register holds a copy of one chosen counter, taken when software writes that counter's index.

Word addresses: status at 0x00, snapshot index at 0x01, snapshot low word at 0x02, snapshot high word at 0x03. Counter i sits at block base 0x10 + 8·i, with control at +0, count low at +1, count high at +2, limit low at +3 and limit high at +4. Control word bits: [0] run, [1] interrupt enable, [2] ignore user mode, [3] ignore kernel mode, [15:8] event index. The `priv_mode` input is 1 for kernel and 0 for user.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, all counts, limits, controls, flags and the snapshot read as zero, and `irq` is low.
- R2: The count is 48 bits. Address +1 loads bits [31:0] and +2 loads bits [47:32]. A step from 0x0_FFFFFFFF carries into the high word.
- R3: A running counter adds exactly one on each clock where the event line chosen by control bits [15:8] is high, whatever the other event lines do.
- R4: A counter's flag (status bit i) is set on the clock where a counting step makes the count equal to its limit, and only if control bit [1] is set at that step.
- R5: Reaching the limit does not stop, wrap or reload the count; it keeps adding one past the limit.
- R6: `irq` is high exactly while at least one status bit is set, and it falls only after a write to the status word.
- R7: Writing the status word clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R8: A cleared flag is not raised again while the count stays past the limit. It is raised again only when a later step lands on the limit.
- R9: Writing index k to 0x01 copies counter k's count into the snapshot (0x02 low, 0x03 high). The copy stays unchanged until the next index write, however the counter moves.
- R10: With control bit [2] set, steps are dropped while `priv_mode` is 0. With control bit [3] set, steps are dropped while `priv_mode` is 1.
- R11: With control bit [0] clear, the count holds its value whatever the events do, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | NUM_EVT | Event condition lines, one per selectable event |
| priv_mode | input | 1 | Current privilege: 1 kernel, 0 user |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq | output | 1 | OR of all counter flags |

## Verification
The bench drives a counter onto its limit and then past it. A design that stops, wraps or reloads at the limit would show the wrong count. One that raises its flag a step early or late would show the wrong status in the cycle the count first equals the limit. It clears one of two raised flags to confirm that `irq` stays high, and writes zero to status to confirm nothing clears. It keeps counting after a clear to catch a flag that wrongly fires again while the count is past the limit. It then reloads below the limit to confirm the flag re-arms. Other cases: a limit reached with interrupts off; a carry across the 32-bit word boundary that lands on a 48-bit limit; all event lines high at once; each privilege filter; a stopped counter; and a snapshot that must not follow the live count.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    localparam int A_STATUS   = 'h00;
    localparam int A_SNAPSEL  = 'h01;
    localparam int A_SNAP_LO  = 'h02;
    localparam int A_SNAP_HI  = 'h03;
    localparam int CTR_BLK0   = 2;      // counter blocks start at 0x10, 8 words each

    localparam int OFF_CTRL   = 0;
    localparam int OFF_CNT_LO = 1;
    localparam int OFF_CNT_HI = 2;
    localparam int OFF_LIM_LO = 3;
    localparam int OFF_LIM_HI = 4;

    typedef struct packed {
        logic [7:0] evt_sel;
        logic [3:0] rsvd;
        logic       skip_kernel;
        logic       skip_user;
        logic       irq_en;
        logic       run;
    } ctrl_t;

    typedef enum logic {
        CTR_ARMED   = 1'b0,
        CTR_FLAGGED = 1'b1
    } ctr_state_e;

endpackage

// File: rtl/ecb_event_gate.sv
module ecb_event_gate
    import ecb_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic [NUM_EVT-1:0] evt_in,
    input  ctrl_t              ctrl,
    input  logic               priv_mode,
    output logic               tick
);

    logic hit;
    logic blocked;
    logic unused_rsvd;

    assign unused_rsvd = ^{ctrl.rsvd, ctrl.irq_en};

    always_comb begin
        hit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (ctrl.evt_sel == 8'(e)) hit = evt_in[e];
        end
    end

    assign blocked = priv_mode ? ctrl.skip_kernel : ctrl.skip_user;
    assign tick    = ctrl.run && hit && !blocked;

endmodule

// File: rtl/ecb_counter.sv
module ecb_counter
    import ecb_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             irq_en,
    input  logic             clr,
    input  logic [1:0]       ld_cnt,   // [0] low word, [1] high word
    input  logic [1:0]       ld_lim,
    input  logic [31:0]      wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] lim_q,
    output logic             flag
);

    localparam int HI_W = CNT_W - 32;

    ctr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d, lim_d, cnt_inc;
    logic             reach;
    logic             unused_wd;

    assign unused_wd = ^wr_data;
    assign cnt_inc   = cnt_q + CNT_W'(1);
    assign reach     = tick && (ld_cnt == 2'b00) && (cnt_inc == lim_q) && irq_en;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_cnt[0]) cnt_d[31:0]       = wr_data;
        if (ld_cnt[1]) cnt_d[CNT_W-1:32] = wr_data[HI_W-1:0];
        if (ld_cnt == 2'b00 && tick) cnt_d = cnt_inc;
    end

    always_comb begin
        lim_d = lim_q;
        if (ld_lim[0]) lim_d[31:0]       = wr_data;
        if (ld_lim[1]) lim_d[CNT_W-1:32] = wr_data[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTR_ARMED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTR_ARMED:   if (reach)          state_d = CTR_FLAGGED;
            CTR_FLAGGED: if (clr && !reach)  state_d = CTR_ARMED;
            default:                         state_d = CTR_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        flag = (state_q == CTR_FLAGGED);
    end

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 16,
    parameter int CNT_W   = 48,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               priv_mode,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic               irq
);

    localparam int BLK_W = ADDR_W - 3;

    ctrl_t              ctrl_q  [NUM_CTR];
    logic [CNT_W-1:0]   cnt_arr [NUM_CTR];
    logic [CNT_W-1:0]   lim_arr [NUM_CTR];
    logic [NUM_CTR-1:0] flag_vec, run_vec, ien_vec, clr_vec;
    logic [NUM_CTR*CNT_W-1:0] cnt_flat;
    logic [CNT_W-1:0]   snap_q, snap_src;
    logic               wr_status, wr_snap;
    logic [2:0]         wr_off, rd_off;
    logic               unused_hi;

    assign wr_status = wr_en && (wr_addr == ADDR_W'(A_STATUS));
    assign wr_snap   = wr_en && (wr_addr == ADDR_W'(A_SNAPSEL));
    assign wr_off    = wr_addr[2:0];
    assign rd_off    = rd_addr[2:0];
    assign clr_vec   = wr_status ? wr_data[NUM_CTR-1:0] : '0;
    assign unused_hi = ^wr_data[31:16];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic blk_wr;
        logic tick;

        assign blk_wr = wr_en && (wr_addr[ADDR_W-1:3] == BLK_W'(CTR_BLK0 + i));

        always_ff @(posedge clk) begin
            if (!rst_n)                             ctrl_q[i] <= '0;
            else if (blk_wr && wr_off == OFF_CTRL)  ctrl_q[i] <= ctrl_t'(wr_data[15:0]);
        end

        ecb_event_gate #(.NUM_EVT(NUM_EVT)) u_gate (
            .evt_in    (evt_in),
            .ctrl      (ctrl_q[i]),
            .priv_mode (priv_mode),
            .tick      (tick)
        );

        ecb_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .irq_en  (ctrl_q[i].irq_en),
            .clr     (clr_vec[i]),
            .ld_cnt  ({blk_wr && wr_off == OFF_CNT_HI, blk_wr && wr_off == OFF_CNT_LO}),
            .ld_lim  ({blk_wr && wr_off == OFF_LIM_HI, blk_wr && wr_off == OFF_LIM_LO}),
            .wr_data (wr_data),
            .cnt_q   (cnt_arr[i]),
            .lim_q   (lim_arr[i]),
            .flag    (flag_vec[i])
        );

        assign run_vec[i] = ctrl_q[i].run;
        assign ien_vec[i] = ctrl_q[i].irq_en;
        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_arr[i];
    end

    assign irq = |flag_vec;

    always_comb begin
        snap_src = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (wr_data == 32'(i)) snap_src = cnt_arr[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (wr_snap) snap_q <= snap_src;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_STATUS))  rd_data = 32'(flag_vec);
        if (rd_addr == ADDR_W'(A_SNAP_LO)) rd_data = snap_q[31:0];
        if (rd_addr == ADDR_W'(A_SNAP_HI)) rd_data = 32'(snap_q[CNT_W-1:32]);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_addr[ADDR_W-1:3] == BLK_W'(CTR_BLK0 + i)) begin
                case (rd_off)
                    3'(OFF_CTRL):   rd_data = 32'(ctrl_q[i]);
                    3'(OFF_CNT_LO): rd_data = cnt_arr[i][31:0];
                    3'(OFF_CNT_HI): rd_data = 32'(cnt_arr[i][CNT_W-1:32]);
                    3'(OFF_LIM_LO): rd_data = lim_arr[i][31:0];
                    3'(OFF_LIM_HI): rd_data = 32'(lim_arr[i][CNT_W-1:32]);
                    default:        rd_data = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ecb_checker.sv
module ecb_checker
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 48,
    parameter int ADDR_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic                     irq,
    input logic [NUM_CTR-1:0]       flag_vec,
    input logic [NUM_CTR-1:0]       ien_vec,
    input logic [NUM_CTR-1:0]       run_vec,
    input logic [NUM_CTR*CNT_W-1:0] cnt_flat,
    input logic [CNT_W-1:0]         snap_q
);

    logic st_wr, snap_wr;
    assign st_wr   = wr_en && (wr_addr == ADDR_W'(A_STATUS));
    assign snap_wr = wr_en && (wr_addr == ADDR_W'(A_SNAPSEL));

    AST_IRQ_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(st_wr)); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec))); // R7

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_wr |=> $stable(snap_q)); // R9

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        AST_FLAG_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[i]) |-> $past(ien_vec[i])); // R4

        AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[i] && !wr_en) |=> $stable(cnt_flat[i*CNT_W +: CNT_W])); // R11
    end

endmodule

bind evt_counter_bank ecb_checker #(
    .NUM_CTR (NUM_CTR),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
) u_ecb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .irq      (irq),
    .flag_vec (flag_vec),
    .ien_vec  (ien_vec),
    .run_vec  (run_vec),
    .cnt_flat (cnt_flat),
    .snap_q   (snap_q)
);

// File: tb/tb_evt_counter_bank.sv
`timescale 1ns/1ps
module tb_evt_counter_bank;

    localparam int NUM_EVT = 16;
    localparam int ADDR_W  = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic               priv_mode = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [31:0]        rd_data;
    logic               irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    evt_counter_bank #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .priv_mode(priv_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // monitor: takes expected items off the scoreboard and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q[0];
                if (it.is_irq) begin
                    #1;
                    act = 32'(irq);
                end else begin
                    rd_addr = it.addr;
                    #1;
                    act = rd_data;
                end
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%02h actual=%0h expected=%0h", it.tag, it.addr, act, it.exp);
                end
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic expect_irq(input logic v, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.addr = 8'hFF; it.exp = 32'(v); it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_EVT-1:0] ev, input int n);
        @(negedge clk);
        evt_in = ev;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(8'h00, 0, "R1 status");
        expect_irq(1'b0, "R1 irq");
        expect_reg(8'h11, 0, "R1 count");
        expect_reg(8'h10, 0, "R1 ctrl");
        expect_reg(8'h13, 0, "R1 limit");
        expect_reg(8'h02, 0, "R1 snapshot");

        // counter 0: event 3, start 10, limit 15
        reg_wr(8'h11, 10);
        reg_wr(8'h12, 0);
        reg_wr(8'h13, 15);
        reg_wr(8'h14, 0);
        reg_wr(8'h10, 32'h0303);
        pulse(16'h0010, 3);
        expect_reg(8'h11, 10, "R3 other event ignored");
        pulse(16'h0008, 3);
        expect_reg(8'h11, 13, "R3 counts selected event");
        expect_reg(8'h00, 0, "R4 no flag before limit");
        pulse(16'h0008, 2);
        expect_reg(8'h11, 15, "R4 count at limit");
        expect_reg(8'h00, 1, "R4 flag on reaching limit");
        expect_irq(1'b1, "R6 irq high");
        pulse(16'h0008, 4);
        expect_reg(8'h11, 19, "R5 counts past limit");
        pulse(16'hFFFF, 1);
        expect_reg(8'h11, 20, "R3 one step with all lines high");

        // R9 snapshot
        reg_wr(8'h01, 0);
        expect_reg(8'h02, 20, "R9 snapshot low");
        expect_reg(8'h03, 0, "R9 snapshot high");
        pulse(16'h0008, 3);
        expect_reg(8'h11, 23, "R5 live count");
        expect_reg(8'h02, 20, "R9 snapshot stable");

        // counter 1: event 5, limit 2
        reg_wr(8'h1B, 2);
        reg_wr(8'h18, 32'h0503);
        pulse(16'h0020, 2);
        expect_reg(8'h00, 3, "R4 two flags");

        // R7 write-one-to-clear
        reg_wr(8'h00, 0);
        expect_reg(8'h00, 3, "R7 zero write no effect");
        reg_wr(8'h00, 1);
        expect_reg(8'h00, 2, "R7 clear bit0 only");
        expect_irq(1'b1, "R6 irq held by remaining flag");
        reg_wr(8'h00, 2);
        expect_reg(8'h00, 0, "R7 clear bit1");
        expect_irq(1'b0, "R6 irq low after all cleared");

        // R8 no re-flag while past limit, re-arm on next landing
        pulse(16'h0008, 2);
        expect_reg(8'h11, 25, "R8 count");
        expect_reg(8'h00, 0, "R8 no re-flag past limit");
        reg_wr(8'h11, 14);
        pulse(16'h0008, 1);
        expect_reg(8'h00, 1, "R8 re-flag on landing");
        reg_wr(8'h00, 1);

        // counter 2: limit reached with irq disabled
        reg_wr(8'h23, 3);
        reg_wr(8'h20, 32'h0601);
        pulse(16'h0040, 5);
        expect_reg(8'h21, 5, "R4 counts with irq off");
        expect_reg(8'h00, 0, "R4 no flag with irq off");

        // R2 carry across word boundary, 48-bit limit
        reg_wr(8'h21, 32'hFFFF_FFFE);
        reg_wr(8'h22, 0);
        reg_wr(8'h23, 0);
        reg_wr(8'h24, 1);
        reg_wr(8'h20, 32'h0603);
        pulse(16'h0040, 2);
        expect_reg(8'h21, 0, "R2 low word after carry");
        expect_reg(8'h22, 1, "R2 high word after carry");
        expect_reg(8'h00, 4, "R2 48-bit limit flag");
        reg_wr(8'h00, 4);

        // R10 privilege filtering on counter 3 (event 7)
        reg_wr(8'h28, 32'h0705);
        priv_mode = 1'b0;
        pulse(16'h0080, 4);
        expect_reg(8'h29, 0, "R10 user steps dropped");
        priv_mode = 1'b1;
        pulse(16'h0080, 2);
        expect_reg(8'h29, 2, "R10 kernel steps counted");
        reg_wr(8'h28, 32'h0709);
        pulse(16'h0080, 3);
        expect_reg(8'h29, 2, "R10 kernel steps dropped");
        priv_mode = 1'b0;
        pulse(16'h0080, 3);
        expect_reg(8'h29, 5, "R10 user steps counted");

        // R11 stopped counter holds, no flag
        reg_wr(8'h11, 14);
        reg_wr(8'h10, 32'h0302);
        pulse(16'h0008, 4);
        expect_reg(8'h11, 14, "R11 stopped counter holds");
        expect_reg(8'h00, 0, "R11 no flag when stopped");
        expect_irq(1'b0, "R6 irq low at end");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule